// File: doc/BRIEF.md
# Gap-Framed Two-Rail Serial Word Receiver

This block takes return-to-zero serial traffic presented as two digital rails, one pulsing for each logic one and the other for each logic zero, and turns it into 32-bit words. Each rail is synchronised to the system clock. A rising edge on the OR of the rails marks a bit, and its value is the state of the ones rail. There is no start marker. A word is framed only by the idle interval that follows it. When both rails stay quiet for a fixed number of gap-clock ticks, the word collected so far is judged. If exactly 32 bits arrived, the word goes to a holding buffer, with an optional odd-parity check that marks a failure in the top bit. Any other count raises a sticky error flag.

Two override inputs let a test source take over the rails, either forcing a one rail, forcing a zero rail, or holding both rails idle. After reset the block discards everything up to the first gap, so it never frames a word it joined part-way through. The buffered word leaves through a valid/ready output. `word_ready` may be held low for any length of time. The buffer then keeps its word and `word_valid` stays high, but a newer complete word always replaces an unaccepted one, so back-pressure never stalls reception. A held word can be lost this way.

Top module: `a429_gap_rx`

## Requirements
- R1: A gap is recognised once GAP_TICKS (default 17) ticks of the gap clock (one tick every GAP_DIV system clocks) pass without a rising edge on either rail. If exactly 32 bits arrived since the previous gap, the word is loaded with the first bit received at `word_data[0]` and the last at `word_data[31]`.
- R2: With `par_en` high at the gap, a word with an even number of ones is loaded with bit 31 forced to 1. A word with odd parity is loaded unchanged.
- R3: With `par_en` low, the loaded word equals the received bits exactly, including bit 31.
- R4: A gap that follows a bit count other than 32 raises `err` and loads no word.
- R5: `err` falls when the next 32-bit word is loaded, or when `rst_n` is low, and at no other time.
- R6: While `rst_n` is low, `word_valid` and `err` are 0. Bits that arrive after reset and before the first gap are discarded, with no word and no error.
- R7: Override inputs `{ovr_one, ovr_zero}` choose the effective rails. 2'b00 passes `line_one`/`line_zero` through. 2'b10 drives the ones rail high. 2'b01 drives the zeros rail high. 2'b11 holds both rails low, so line activity is ignored.
- R8: A long idle period yields only one gap event, so it produces no extra word and no error.
- R9: `word_valid` stays high with `word_data` stable until a cycle with `word_ready` high. A newer word overwrites an unaccepted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| line_one | input | 1 | Ones rail from the line receiver |
| line_zero | input | 1 | Zeros rail from the line receiver |
| ovr_one | input | 1 | Test override, ones side |
| ovr_zero | input | 1 | Test override, zeros side |
| par_en | input | 1 | Enables odd-parity marking of bit 31 |
| word_data | output | WORD_BITS | Buffered word |
| word_valid | output | 1 | Buffer holds an unaccepted word |
| word_ready | input | 1 | Consumer accepts the word this cycle |
| err | output | 1 | Sticky bit-count error |

## Verification
A rail's rising edge reaches the shift register three clocks later: two synchroniser stages plus the edge detector. The gap fires GAP_TICKS to GAP_TICKS+1 gap-clock periods after the last edge. `word_valid` and `err` change on the clock right after the gap. The bench therefore holds each bit for four clocks high and four low. After every word it idles for 120 clocks, well beyond the 17×4 clocks of a gap plus synchroniser delay, and only then samples `err` and `word_valid` on a falling clock edge. Delivered words are compared by a monitor at the handshake, whenever that happens, so the comparison does not depend on exact arrival timing.

// File: rtl/a429_pkg.sv
package a429_pkg;
  localparam int unsigned WORD_BITS_DEF = 32;

  typedef struct packed {
    logic one;
    logic zero;
  } rail_t;

  typedef enum logic [1:0] {
    OVR_PASS = 2'b00,
    OVR_ZERO = 2'b01,
    OVR_ONE  = 2'b10,
    OVR_IDLE = 2'b11
  } ovr_mode_e;
endpackage

// File: rtl/a429_rail_front.sv
module a429_rail_front
  import a429_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_one,
  input  logic line_zero,
  input  logic ovr_one,
  input  logic ovr_zero,
  output logic bit_stb,
  output logic bit_val
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  ovr_mode_e mode;
  rail_t     eff;

  always_comb begin
    mode = ovr_mode_e'({ovr_one, ovr_zero});
    unique case (mode)
      OVR_PASS: eff = '{one: line_one, zero: line_zero};
      OVR_ZERO: eff = '{one: 1'b0, zero: 1'b1};
      OVR_ONE:  eff = '{one: 1'b1, zero: 1'b0};
      default:  eff = '{one: 1'b0, zero: 1'b0};
    endcase
  end

  logic [SYNC_STAGES-1:0] s_one, s_zero;

  generate
    if (SYNC_STAGES == 1) begin : g_one_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s_one  <= '0;
          s_zero <= '0;
        end else begin
          s_one  <= eff.one;
          s_zero <= eff.zero;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s_one  <= '0;
          s_zero <= '0;
        end else begin
          s_one  <= {s_one[SYNC_STAGES-2:0], eff.one};
          s_zero <= {s_zero[SYNC_STAGES-2:0], eff.zero};
        end
      end
    end
  endgenerate

  logic act, act_q;
  assign act = s_one[LAST] | s_zero[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end

  assign bit_stb = act & ~act_q;
  assign bit_val = s_one[LAST];
endmodule

// File: rtl/a429_gap_timer.sv
module a429_gap_timer #(
  parameter int unsigned GAP_DIV   = 4,
  parameter int unsigned GAP_TICKS = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_edge,
  output logic gap_evt
);
  localparam int unsigned IC_W = $clog2(GAP_TICKS + 1);
  localparam logic [IC_W-1:0] IC_TOP = IC_W'(GAP_TICKS);

  logic tick;

  generate
    if (GAP_DIV <= 1) begin : g_no_div
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(GAP_DIV);
      localparam logic [PW-1:0] P_TOP = PW'(GAP_DIV - 1);
      logic [PW-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pre <= '0;
        else if (pre == P_TOP) pre <= '0;
        else                 pre <= pre + 1'b1;
      end
      assign tick = (pre == P_TOP);
    end
  endgenerate

  logic [IC_W-1:0] ic;
  logic            fired;

  assign gap_evt = (ic == IC_TOP) && !fired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ic    <= '0;
      fired <= 1'b0;
    end else if (act_edge) begin
      ic    <= '0;
      fired <= 1'b0;
    end else begin
      if (tick && ic != IC_TOP) ic <= ic + 1'b1;
      if (gap_evt)              fired <= 1'b1;
    end
  end
endmodule

// File: rtl/a429_framer.sv
module a429_framer #(
  parameter int unsigned WORD_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_stb,
  input  logic                 bit_val,
  input  logic                 gap_evt,
  input  logic                 par_en,
  output logic                 load,
  output logic [WORD_BITS-1:0] load_word,
  output logic                 err
);
  localparam int unsigned CNT_W = $clog2(WORD_BITS + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_BITS);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(WORD_BITS + 1);

  logic [WORD_BITS-1:0] shreg;
  logic [CNT_W-1:0]     cnt, cnt_base;
  logic                 init;
  logic                 even_par;

  assign even_par = ~^shreg;
  assign load     = gap_evt && !init && (cnt == FULL);

  always_comb begin
    load_word = shreg;
    if (par_en && even_par) load_word[WORD_BITS-1] = 1'b1;
  end

  assign cnt_base = gap_evt ? '0 : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      init  <= 1'b1;
      err   <= 1'b0;
    end else begin
      if (bit_stb) begin
        shreg <= {bit_val, shreg[WORD_BITS-1:1]};
        cnt   <= (cnt_base == SAT) ? SAT : cnt_base + 1'b1;
      end else begin
        cnt   <= cnt_base;
      end
      if (gap_evt) begin
        if (init)              init <= 1'b0;
        else if (cnt == FULL)  err  <= 1'b0;
        else                   err  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/a429_word_buf.sv
module a429_word_buf #(
  parameter int unsigned WORD_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [WORD_BITS-1:0] load_word,
  output logic [WORD_BITS-1:0] word_data,
  output logic                 word_valid,
  input  logic                 word_ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_data  <= '0;
      word_valid <= 1'b0;
    end else if (load) begin
      word_data  <= load_word;
      word_valid <= 1'b1;
    end else if (word_valid && word_ready) begin
      word_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/a429_gap_rx.sv
module a429_gap_rx
  import a429_pkg::*;
#(
  parameter int unsigned WORD_BITS   = WORD_BITS_DEF,
  parameter int unsigned GAP_DIV     = 4,
  parameter int unsigned GAP_TICKS   = 17,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_one,
  input  logic                 line_zero,
  input  logic                 ovr_one,
  input  logic                 ovr_zero,
  input  logic                 par_en,
  output logic [WORD_BITS-1:0] word_data,
  output logic                 word_valid,
  input  logic                 word_ready,
  output logic                 err
);
  logic                 bit_stb, bit_val, gap_evt, load;
  logic [WORD_BITS-1:0] load_word;

  a429_rail_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n),
    .line_one(line_one), .line_zero(line_zero),
    .ovr_one(ovr_one), .ovr_zero(ovr_zero),
    .bit_stb(bit_stb), .bit_val(bit_val)
  );

  a429_gap_timer #(.GAP_DIV(GAP_DIV), .GAP_TICKS(GAP_TICKS)) u_gap (
    .clk(clk), .rst_n(rst_n), .act_edge(bit_stb), .gap_evt(gap_evt)
  );

  a429_framer #(.WORD_BITS(WORD_BITS)) u_frm (
    .clk(clk), .rst_n(rst_n),
    .bit_stb(bit_stb), .bit_val(bit_val), .gap_evt(gap_evt),
    .par_en(par_en), .load(load), .load_word(load_word), .err(err)
  );

  a429_word_buf #(.WORD_BITS(WORD_BITS)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(load), .load_word(load_word),
    .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready)
  );
endmodule

// File: rtl/a429_gap_rx_chk.sv
module a429_gap_rx_chk #(
  parameter int unsigned WORD_BITS = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ovr_one,
  input logic                 ovr_zero,
  input logic                 par_en,
  input logic [WORD_BITS-1:0] word_data,
  input logic                 word_valid,
  input logic                 word_ready,
  input logic                 err,
  input logic                 load,
  input logic                 gap_evt,
  input logic                 bit_stb
);
  a_r1_load_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> gap_evt);

  a_r2_parity_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (load && par_en) |=> (word_data[WORD_BITS-1] || (^word_data)));

  a_r4_err_from_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($past(gap_evt) && !$past(load)));

  a_r5_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !err);

  a_r7_forced_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_one && ovr_zero && $past(ovr_one && ovr_zero) && $past(ovr_one && ovr_zero, 2))
      |-> !bit_stb);

  a_r8_single_gap: assert property (@(posedge clk) disable iff (!rst_n)
    gap_evt |=> !gap_evt);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready && !load) |=> (word_valid && $stable(word_data)));
endmodule

bind a429_gap_rx a429_gap_rx_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ovr_one(ovr_one), .ovr_zero(ovr_zero),
  .par_en(par_en), .word_data(word_data), .word_valid(word_valid),
  .word_ready(word_ready), .err(err), .load(load), .gap_evt(gap_evt),
  .bit_stb(bit_stb)
);

// File: tb/sim_a429_gap_rx.sv
module sim_a429_gap_rx;
  localparam int IDLE = 120;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_one = 1'b0, line_zero = 1'b0;
  logic        ovr_one = 1'b0, ovr_zero = 1'b0;
  logic        par_en = 1'b0;
  logic        word_ready = 1'b1;
  logic [31:0] word_data;
  logic        word_valid, err;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  a429_gap_rx u0 (
    .clk(clk), .rst_n(rst_n), .line_one(line_one), .line_zero(line_zero),
    .ovr_one(ovr_one), .ovr_zero(ovr_zero), .par_en(par_en),
    .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
    .err(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] w, input logic pe);
    if (pe && !(^w)) return w | 32'h8000_0000;
    return w;
  endfunction

  task automatic push(input logic [31:0] w, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [31:0] w, input int n, input bit via_tst);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = (i < 32) ? w[i] : 1'b0;
      if (via_tst) {ovr_one, ovr_zero} = b ? 2'b10 : 2'b01;
      else         {line_one, line_zero} = b ? 2'b10 : 2'b01;
      repeat (4) @(negedge clk);
      if (via_tst) {ovr_one, ovr_zero} = 2'b00;
      else         {line_one, line_zero} = 2'b00;
      repeat (4) @(negedge clk);
    end
    repeat (IDLE) @(negedge clk);
  endtask

  // scoreboard monitor: compares each word at its handshake
  always @(negedge clk) begin
    if (rst_n && word_valid && word_ready) begin
      if (exp_q.size() == 0) chk("R8 unexpected word", word_data, 32'hxxxx_xxxx);
      else chk(tag_q.pop_front(), word_data, exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 valid in reset", {31'b0, word_valid}, 32'd0);
    chk("R6 err in reset", {31'b0, err}, 32'd0);
    rst_n = 1'b1;
    // R6: partial word before the first gap is discarded
    send(32'h0000_03FF, 10, 1'b0);
    chk("R6 no word after partial", {31'b0, word_valid}, 32'd0);
    chk("R6 no err after partial", {31'b0, err}, 32'd0);

    // R1 and R3: plain word, parity off
    par_en = 1'b0;
    push(32'hA5A5_0F0F, "R1 word order");
    send(32'hA5A5_0F0F, 32, 1'b0);
    chk("R1 err low after good word", {31'b0, err}, 32'd0);
    push(32'h0000_0003, "R3 even word unchanged");
    send(32'h0000_0003, 32, 1'b0);
    push(32'h8000_0011, "R3 bit31 as received");
    send(32'h8000_0011, 32, 1'b0);

    // R2: parity on
    par_en = 1'b1;
    push(model(32'h0000_0003, 1'b1), "R2 even parity marked");
    send(32'h0000_0003, 32, 1'b0);
    push(model(32'h0000_0001, 1'b1), "R2 odd parity unchanged");
    send(32'h0000_0001, 32, 1'b0);
    par_en = 1'b0;

    // R7: bits via override inputs
    push(32'h1234_5678, "R7 override rails");
    send(32'h1234_5678, 32, 1'b1);
    // R7: both overrides high mask line activity
    {ovr_one, ovr_zero} = 2'b11;
    send(32'hFFFF_0000, 32, 1'b0);
    chk("R7 masked no word", {31'b0, word_valid}, 32'd0);
    chk("R7 masked no err", {31'b0, err}, 32'd0);
    {ovr_one, ovr_zero} = 2'b00;
    repeat (IDLE) @(negedge clk);

    // R4 short word, R5 cleared by next good word
    send(32'h0000_7FFF, 31, 1'b0);
    chk("R4 short count err", {31'b0, err}, 32'd1);
    chk("R4 short count no word", {31'b0, word_valid}, 32'd0);
    push(32'h0F0F_F0F0, "R5 good word after error");
    send(32'h0F0F_F0F0, 32, 1'b0);
    chk("R5 err cleared by word", {31'b0, err}, 32'd0);

    // R4 long word, R5 cleared by reset
    send(32'hFFFF_FFFF, 33, 1'b0);
    chk("R4 long count err", {31'b0, err}, 32'd1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 err cleared by reset", {31'b0, err}, 32'd0);
    rst_n = 1'b1;
    repeat (IDLE) @(negedge clk);
    push(32'hC3C3_3C3C, "R6 receive after reset gap");
    send(32'hC3C3_3C3C, 32, 1'b0);

    // R9: back-pressure and overwrite
    word_ready = 1'b0;
    send(32'h1111_2222, 32, 1'b0);
    chk("R9 held valid", {31'b0, word_valid}, 32'd1);
    chk("R9 held data", word_data, 32'h1111_2222);
    send(32'h3333_4444, 32, 1'b0);
    chk("R9 overwritten data", word_data, 32'h3333_4444);
    push(32'h3333_4444, "R9 newest word delivered");
    word_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 valid drops after accept", {31'b0, word_valid}, 32'd0);

    // R8: long idle yields nothing more
    repeat (400) @(negedge clk);
    chk("R8 no extra word", {31'b0, word_valid}, 32'd0);
    chk("R8 no extra err", {31'b0, err}, 32'd0);
    chk("R1 all expected words seen", exp_q.size(), 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule